// File: doc/BRIEF.md
# Keyed Clock-Source Control Register

This block holds the clock-source configuration of a chip. Bus masters reach it through a simple register-select, write-enable and write-data interface. Its outputs drive an oscillator switch: a two-bit source select, three oscillator enables, a low-power flag and a fail-detect enable. A divider value is loaded at reset. A wrong write to this register could move the chip onto a dead oscillator, so the register is write-protected. It accepts a data write only after two key bytes arrive in order: first `0xE7`, then `0x18`. The single data write that follows is committed, and the register locks again at once.

The key state machine has three states. `KEY_IDLE` is the locked start. `KEY_HALF` means the first key has been seen. `KEY_OPEN` means the next write will be accepted. Its transitions are:

- **T_FIRST**: `KEY_IDLE` goes to `KEY_HALF` on a write of `0xE7`.
- **T_SECOND**: `KEY_HALF` goes to `KEY_OPEN` on a write of `0x18`.
- **T_RESTART**: `KEY_HALF` stays in `KEY_HALF` on another write of `0xE7`.
- **T_ABORT**: `KEY_HALF` goes to `KEY_IDLE` on any other write value.
- **T_COMMIT**: `KEY_OPEN` goes to `KEY_IDLE` on any write, and that write stores its data.

Cycles in which this register is not written leave the state where it is. That includes accesses to other registers. A separate edge detector turns a rising primary-oscillator fail flag into a one-cycle exception request. The request is raised only while fail detection is enabled.

Top module: `clksrc_guard`

## Requirements
- R1: With `lowpwr_opt` = 1 during reset, the block comes out locked (`wr_open` = 0) with control value 0x40 and `div_val` = 0x01. Field layout of the control value: [1:0] source select (00 = internal precision oscillator), bit 2 external oscillator enable, bit 3 timer oscillator enable, bit 4 low-power enable, bit 5 fail-detect enable, bit 6 internal oscillator enable, bit 7 reads 0.
- R2: With `lowpwr_opt` = 0 during reset, the control value is 0x50 (bit 4 set) and `div_val` = 0x08.
- R3: A write of 0xE7 followed later by a write of 0x18 sets `wr_open` in the cycle after the 0x18 write's clock edge.
- R4: Idle cycles, reads, and writes with `reg_sel` = 0 between the two keys, or after them, leave the unlock progress unchanged.
- R5: While `wr_open` = 1, the next write stores its data with bit 7 forced to 0 and clears `wr_open` at the same clock edge.
- R6: A write made while `wr_open` = 0 never changes the control value.
- R7: In `KEY_HALF`, a write of a value other than 0xE7 or 0x18 returns the block to `KEY_IDLE`. A write of 0x18 in `KEY_IDLE` does not advance the sequence. A write of 0xE7 in `KEY_HALF` keeps the sequence at `KEY_HALF`.
- R8: `reg_rdata` always shows the current control value, and reads have no effect on the lock state.
- R9: `src_sel`, `xosc_en`, `wosc_en`, `lp_en`, `fdet_en` and `iosc_en` follow the control value fields listed in R1.
- R10: A 0-to-1 edge of `osc_fail`, sampled while fail detect (bit 5) is 1, gives a `fail_exc` pulse exactly one cycle long. No pulse is given when bit 5 is 0, and no pulse is given while `osc_fail` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lowpwr_opt | input | 1 | Reset-time option bit; 0 selects low-power start |
| reg_sel | input | 1 | Register-select strobe for this register |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control value |
| osc_fail | input | 1 | Primary oscillator fail flag |
| src_sel | output | 2 | Clock source select |
| xosc_en | output | 1 | External oscillator enable |
| wosc_en | output | 1 | Timer oscillator enable |
| iosc_en | output | 1 | Internal oscillator enable |
| lp_en | output | 1 | Low-power enable |
| fdet_en | output | 1 | Fail-detect enable |
| div_val | output | 8 | Clock divider value |
| wr_open | output | 1 | High when the next write will be accepted |
| fail_exc | output | 1 | One-cycle fail exception request |

## Verification
Every registered result follows one clock edge after its stimulus. A write presented before edge k changes the lock state and the control value seen after edge k. A rising `osc_fail` before edge k raises `fail_exc` after edge k, and it is cleared after edge k+1. The bench drives inputs on falling edges and samples on the next falling edge, so each check lands in the first cycle in which the new value is due. The pulse check also samples one cycle later to prove the pulse ends.

// File: rtl/clksrc_guard_pkg.sv
package clksrc_guard_pkg;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;

    localparam int CTRL_W = 8;

    // field positions of the control value
    localparam int F_SRC_LO = 0;
    localparam int F_SRC_HI = 1;
    localparam int F_XOSC   = 2;
    localparam int F_WOSC   = 3;
    localparam int F_LP     = 4;
    localparam int F_FDET   = 5;
    localparam int F_IOSC   = 6;
    localparam int F_RSV    = 7;

    localparam logic [CTRL_W-1:0] CTRL_BASE = 8'h40;

endpackage

// File: rtl/clksrc_key_fsm.sv
module clksrc_key_fsm
    import clksrc_guard_pkg::*;
#(
    parameter int                 DATA_W = 8,
    parameter logic [DATA_W-1:0]  KEY_A  = 8'hE7,
    parameter logic [DATA_W-1:0]  KEY_B  = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic              open,
    output logic              commit
);

    key_state_e state_q;
    key_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_stb) begin
            unique case (state_q)
                KEY_IDLE: begin
                    if (wdata == KEY_A) state_d = KEY_HALF;   // T_FIRST
                end
                KEY_HALF: begin
                    if (wdata == KEY_B)      state_d = KEY_OPEN; // T_SECOND
                    else if (wdata == KEY_A) state_d = KEY_HALF; // T_RESTART
                    else                     state_d = KEY_IDLE; // T_ABORT
                end
                KEY_OPEN: begin
                    state_d = KEY_IDLE;                      // T_COMMIT
                end
                default: state_d = KEY_IDLE;
            endcase
        end
    end

    always_comb begin
        open   = (state_q == KEY_OPEN);
        commit = open && wr_stb;
    end

endmodule

// File: rtl/clksrc_cfg_reg.sv
module clksrc_cfg_reg
    import clksrc_guard_pkg::*;
#(
    parameter int               DIV_W    = 8,
    parameter logic [DIV_W-1:0] DIV_NORM = 8'h01,
    parameter logic [DIV_W-1:0] DIV_LP   = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lowpwr_opt,
    input  logic              commit,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl,
    output logic [DIV_W-1:0]  div
);

    logic [CTRL_W-1:0] wmask;
    logic [CTRL_W-1:0] rst_val;

    // per-bit write mask: the reserved bit is never stored
    for (genvar b = 0; b < CTRL_W; b++) begin : g_mask
        if (b == F_RSV) begin : g_rsv
            assign wmask[b] = 1'b0;
        end else begin : g_fld
            assign wmask[b] = 1'b1;
        end
    end

    always_comb begin
        rst_val = CTRL_BASE;
        rst_val[F_LP] = ~lowpwr_opt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= rst_val;
            div  <= lowpwr_opt ? DIV_NORM : DIV_LP;
        end else if (commit) begin
            ctrl <= wdata & wmask;
        end
    end

endmodule

// File: rtl/clksrc_fail_pulse.sv
module clksrc_fail_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_in,
    input  logic enable,
    output logic exc
);

    logic fail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            exc    <= 1'b0;
        end else begin
            fail_q <= fail_in;
            exc    <= enable && fail_in && !fail_q;
        end
    end

endmodule

// File: rtl/clksrc_guard.sv
module clksrc_guard
    import clksrc_guard_pkg::*;
#(
    parameter int               DIV_W    = 8,
    parameter logic [7:0]       KEY_A    = 8'hE7,
    parameter logic [7:0]       KEY_B    = 8'h18,
    parameter logic [DIV_W-1:0] DIV_NORM = 8'h01,
    parameter logic [DIV_W-1:0] DIV_LP   = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lowpwr_opt,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             osc_fail,
    output logic [1:0]       src_sel,
    output logic             xosc_en,
    output logic             wosc_en,
    output logic             iosc_en,
    output logic             lp_en,
    output logic             fdet_en,
    output logic [DIV_W-1:0] div_val,
    output logic             wr_open,
    output logic             fail_exc
);

    logic              wr_stb;
    logic              commit;
    logic [CTRL_W-1:0] ctrl;

    assign wr_stb = reg_sel && reg_we;

    clksrc_key_fsm #(
        .DATA_W (CTRL_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .wdata  (reg_wdata),
        .open   (wr_open),
        .commit (commit)
    );

    clksrc_cfg_reg #(
        .DIV_W    (DIV_W),
        .DIV_NORM (DIV_NORM),
        .DIV_LP   (DIV_LP)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .lowpwr_opt (lowpwr_opt),
        .commit     (commit),
        .wdata      (reg_wdata),
        .ctrl       (ctrl),
        .div        (div_val)
    );

    clksrc_fail_pulse u_fail (
        .clk     (clk),
        .rst_n   (rst_n),
        .fail_in (osc_fail),
        .enable  (ctrl[F_FDET]),
        .exc     (fail_exc)
    );

    always_comb begin
        reg_rdata = ctrl;
        src_sel   = ctrl[F_SRC_HI:F_SRC_LO];
        xosc_en   = ctrl[F_XOSC];
        wosc_en   = ctrl[F_WOSC];
        iosc_en   = ctrl[F_IOSC];
        lp_en     = ctrl[F_LP];
        fdet_en   = ctrl[F_FDET];
    end

endmodule

// File: rtl/clksrc_guard_chk.sv
module clksrc_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       we,
    input logic [7:0] wdata,
    input logic [7:0] ctrl,
    input logic       open,
    input logic       exc,
    input logic       fdet
);

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(sel && we && wdata == 8'h18)); // R3

    AST_IDLE_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && we) |=> $stable(open)); // R4

    AST_COMMIT_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (open && sel && we) |=> !open); // R5

    AST_COMMIT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (open && sel && we) |=> ctrl == ($past(wdata) & 8'h7F)); // R5

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(ctrl)); // R6

    AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exc |=> !exc); // R10

    AST_EXC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> $past(fdet)); // R10

endmodule

bind clksrc_guard clksrc_guard_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (reg_sel),
    .we    (reg_we),
    .wdata (reg_wdata),
    .ctrl  (reg_rdata),
    .open  (wr_open),
    .exc   (fail_exc),
    .fdet  (fdet_en)
);

// File: tb/test_clksrc_guard.sv
module test_clksrc_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lowpwr_opt = 1'b1;
    logic       reg_sel = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       osc_fail = 1'b0;
    logic [1:0] src_sel;
    logic       xosc_en, wosc_en, iosc_en, lp_en, fdet_en;
    logic [7:0] div_val;
    logic       wr_open;
    logic       fail_exc;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    clksrc_guard i_clksrc_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .lowpwr_opt (lowpwr_opt),
        .reg_sel    (reg_sel),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .osc_fail   (osc_fail),
        .src_sel    (src_sel),
        .xosc_en    (xosc_en),
        .wosc_en    (wosc_en),
        .iosc_en    (iosc_en),
        .lp_en      (lp_en),
        .fdet_en    (fdet_en),
        .div_val    (div_val),
        .wr_open    (wr_open),
        .fail_exc   (fail_exc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic opt);
        @(negedge clk);
        rst_n = 1'b0; lowpwr_opt = opt; reg_sel = 0; reg_we = 0; osc_fail = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one bus cycle; results checked at the following falling edge
    task automatic bus(input logic s, input logic w, input logic [7:0] d);
        reg_sel = s; reg_we = w; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_we = 0;
    endtask

    task automatic unlock();
        bus(1, 1, 8'hE7);
        bus(1, 1, 8'h18);
    endtask

    task automatic t_reset_normal();
        do_reset(1'b1);
        check("R1 lock", wr_open, 0);
        check("R1 ctrl", reg_rdata, 8'h40);
        check("R1 div", div_val, 8'h01);
    endtask

    task automatic t_reset_lowpwr();
        do_reset(1'b0);
        check("R2 ctrl", reg_rdata, 8'h50);
        check("R2 div", div_val, 8'h08);
        check("R2 lp_en", lp_en, 1);
    endtask

    task automatic t_spaced_unlock();
        do_reset(1'b1);
        bus(1, 1, 8'hE7);
        check("R3 half not open", wr_open, 0);
        bus(0, 0, 8'h00);
        bus(0, 1, 8'h33);       // write to another register
        bus(1, 0, 8'h55);       // read of this register
        check("R8 read no effect", reg_rdata, 8'h40);
        bus(1, 1, 8'h18);
        check("R3 open after keys", wr_open, 1);
        bus(0, 1, 8'h99);
        bus(0, 0, 8'h00);
        check("R4 open survives others", wr_open, 1);
        bus(1, 1, 8'hA5);
        check("R5 relocked", wr_open, 0);
        check("R5 stored, bit7 clear", reg_rdata, 8'h25);
        check("R9 src_sel", src_sel, 2'b01);
        check("R9 xosc_en", xosc_en, 1);
        check("R9 fdet_en", fdet_en, 1);
        check("R9 iosc_en", iosc_en, 0);
        bus(1, 1, 8'h0F);
        check("R6 second write ignored", reg_rdata, 8'h25);
    endtask

    task automatic t_bad_sequences();
        do_reset(1'b1);
        bus(1, 1, 8'h18);
        bus(1, 1, 8'h18);
        check("R7 wrong order no open", wr_open, 0);
        check("R6 value kept", reg_rdata, 8'h40);
        bus(1, 1, 8'hE7);
        bus(1, 1, 8'h42);       // abort
        bus(1, 1, 8'h18);
        check("R7 abort to idle", wr_open, 0);
        bus(1, 1, 8'hE7);
        bus(1, 1, 8'hE7);       // restart stays half
        bus(1, 1, 8'h18);
        check("R7 repeated first key", wr_open, 1);
        bus(1, 1, 8'h08);
        check("R5 commit wosc", wosc_en, 1);
        check("R5 ctrl", reg_rdata, 8'h08);
    endtask

    task automatic t_fail_pulse();
        do_reset(1'b1);
        osc_fail = 1'b1;
        @(negedge clk);
        check("R10 no pulse when disabled", fail_exc, 0);
        osc_fail = 1'b0;
        unlock();
        bus(1, 1, 8'h60);       // fail detect on, internal osc on
        check("R10 enable set", fdet_en, 1);
        osc_fail = 1'b1;
        @(negedge clk);
        check("R10 pulse", fail_exc, 1);
        @(negedge clk);
        check("R10 pulse ends", fail_exc, 0);
        @(negedge clk);
        check("R10 level gives no pulse", fail_exc, 0);
        osc_fail = 1'b0;
    endtask

    initial begin
        fork
            begin
                t_reset_normal();
                t_reset_lowpwr();
                t_spaced_unlock();
                t_bad_sequences();
                t_fail_pulse();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule